// File: doc/BRIEF.md
# Running Priority Tracker with Nested Priority Drop

This block follows the running priority of one interrupt CPU interface while interrupts are taken, nested by preemption and finished. Each acknowledge carries the taken interrupt's 8-bit priority, an NMI marker and a binary point. The block keeps only the group-priority part of that priority. Each priority-drop event then retires the most urgent level that is still active, so the running priority falls back to the level that was preempted. When nothing is left, it returns to the idle value.

The arbiter reads the current running priority. It also reads a flag that says whether the level setting that priority belongs to an NMI, which it needs for its equal-priority NMI rule. A read-only view of the whole active-level set is exported for a register read path. Two kinds of event the arbiter should never send raise one-cycle error pulses and leave the state unchanged: an acknowledge that does not preempt, and a drop while idle.

Top module: `rpt_running_prio`

## Requirements
- R1: After reset, and whenever no level is active, `runPrio` is 0xFF, `activeSet` is all zero, and `runIsNmi` and both error pulses are 0.
- R2: The group priority of an acknowledge is `ackPrio` with bits [binPoint:0] forced to zero. Bits below the implemented width are also forced to zero: with the default of 5 implemented bits, bits [2:0] are always zero. An accepted acknowledge makes `runPrio` equal that group priority in the cycle after the acknowledge.
- R3: Active levels are kept as a set. Bit k of `activeSet` means group priority k·2^(8−PRIO_BITS) is active, so by default bit k stands for priority 8·k. `runPrio` is the value of the lowest-numbered set bit, and nesting any number of strictly more urgent acknowledges keeps every earlier level in the set.
- R4: A priority drop clears the lowest-numbered set bit in the following cycle. `runPrio` returns to the preempted level, and to 0xFF once the set is empty.
- R5: An acknowledge whose group priority is numerically equal to or greater than the current `runPrio` is rejected. `ackReject` is high for the one cycle after it, and the active set is unchanged.
- R6: A priority drop while the set is empty leaves the state unchanged, and `dropError` is high for the one cycle after it.
- R7: `runIsNmi` is 1 exactly when the level that currently sets `runPrio` was entered by an acknowledge with `ackNmi` = 1. It is 0 while idle.
- R8: When an acknowledge and a drop arrive in the same cycle, the acknowledge is judged against the running priority before the drop. The drop removes the old most urgent level, and an accepted acknowledge adds its own level. Both take effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ackValid | input | 1 | Acknowledge strobe for one interrupt |
| ackPrio | input | 8 | Full priority of the acknowledged interrupt |
| ackNmi | input | 1 | Acknowledged interrupt is an NMI |
| binPoint | input | 3 | Binary point; bits [binPoint:0] are subpriority |
| dropValid | input | 1 | Priority-drop (end-of-interrupt) strobe |
| runPrio | output | 8 | Current running priority, 0xFF when idle |
| runIsNmi | output | 1 | Level setting `runPrio` belongs to an NMI |
| activeSet | output | 2^PRIO_BITS | Register view of active group-priority levels |
| ackReject | output | 1 | Pulse: last acknowledge did not preempt |
| dropError | output | 1 | Pulse: last drop found nothing active |

## Verification
An acknowledge and a priority drop can fall in the same cycle. This is the ordering most likely to be got wrong, because the acceptance test could wrongly use the post-drop priority, or the drop could wrongly remove the newly pushed level. The bench drives both strobes together in two cases: a more urgent acknowledge over a two-level nest, and a non-preempting acknowledge over a single level. In each case it judges the next-cycle running priority, the full active set and the reject pulse against values worked out by hand from R8.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

  // Strobes sent from the control decision logic to the level store.
  typedef struct packed {
    logic              push;      // add pushLevel to the active set
    logic              pop;       // retire the most urgent active level
    logic [PRIO_W-1:0] pushLevel; // group priority being added
    logic              pushNmi;   // added level belongs to an NMI
    logic              rejectErr; // acknowledge did not preempt
    logic              dropErr;   // drop arrived with nothing active
  } rptStrobe_t;

endpackage

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
#(
  parameter int PRIO_BITS = 5
) (
  input  logic              ackValid,
  input  logic [PRIO_W-1:0] ackPrio,
  input  logic              ackNmi,
  input  logic [2:0]        binPoint,
  input  logic              dropValid,
  input  logic [PRIO_W-1:0] curRunPrio,
  input  logic              setEmpty,
  output rptStrobe_t        strobe
);

  localparam int SHIFT = PRIO_W - PRIO_BITS;
  localparam logic [PRIO_W-1:0] IMPL_MASK = 8'(8'hFF << SHIFT);

  logic [3:0]        subBits;
  logic [PRIO_W-1:0] subMask;
  logic [PRIO_W-1:0] groupPrio;
  logic              preempts;

  always_comb begin
    subBits   = {1'b0, binPoint} + 4'd1;
    subMask   = 8'(8'hFF << subBits);
    groupPrio = ackPrio & subMask & IMPL_MASK;
    // Judged against the running priority before any same-cycle drop.
    preempts  = groupPrio < curRunPrio;
  end

  always_comb begin
    strobe           = '0;
    strobe.push      = ackValid && preempts;
    strobe.pushLevel = groupPrio;
    strobe.pushNmi   = ackNmi;
    strobe.rejectErr = ackValid && !preempts;
    strobe.pop       = dropValid && !setEmpty;
    strobe.dropErr   = dropValid && setEmpty;
  end

endmodule

// File: rtl/rpt_datapath.sv
module rpt_datapath
  import rpt_pkg::*;
#(
  parameter int PRIO_BITS = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rptStrobe_t                  strobe,
  output logic [PRIO_W-1:0]           runPrio,
  output logic                        runIsNmi,
  output logic                        setEmpty,
  output logic [(1<<PRIO_BITS)-1:0]   activeSet,
  output logic                        ackReject,
  output logic                        dropError
);

  localparam int LEVELS = 1 << PRIO_BITS;
  localparam int SHIFT  = PRIO_W - PRIO_BITS;

  logic [LEVELS-1:0] activeQ, nmiQ;
  logic [LEVELS-1:0] activeD, nmiD;
  logic [LEVELS-1:0] lowestOh;
  logic [LEVELS-1:0] pushHit;
  logic [PRIO_W-1:0] lowPrio;
  logic              rejectQ, dropErrQ;

  // Decode the pushed group priority onto one level bit.
  for (genvar k = 0; k < LEVELS; k++) begin : g_hit
    assign pushHit[k] = strobe.push && (strobe.pushLevel == 8'(k << SHIFT));
  end

  always_comb begin
    lowestOh = activeQ & (~activeQ + 1'b1);
    lowPrio  = IDLE_PRIO;
    for (int k = LEVELS - 1; k >= 0; k--) begin
      if (activeQ[k]) lowPrio = 8'(k << SHIFT);
    end
  end

  always_comb begin
    activeD = activeQ;
    nmiD    = nmiQ;
    if (strobe.pop) begin
      activeD = activeD & ~lowestOh;
      nmiD    = nmiD & ~lowestOh;
    end
    activeD = activeD | pushHit;
    nmiD    = strobe.pushNmi ? (nmiD | pushHit) : (nmiD & ~pushHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ  <= '0;
      nmiQ     <= '0;
      rejectQ  <= 1'b0;
      dropErrQ <= 1'b0;
    end else begin
      activeQ  <= activeD;
      nmiQ     <= nmiD;
      rejectQ  <= strobe.rejectErr;
      dropErrQ <= strobe.dropErr;
    end
  end

  assign setEmpty  = ~|activeQ;
  assign runPrio   = lowPrio;
  assign runIsNmi  = |(nmiQ & lowestOh);
  assign activeSet = activeQ;
  assign ackReject = rejectQ;
  assign dropError = dropErrQ;

endmodule

// File: rtl/rpt_running_prio.sv
module rpt_running_prio
  import rpt_pkg::*;
#(
  parameter int PRIO_BITS = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      ackValid,
  input  logic [7:0]                ackPrio,
  input  logic                      ackNmi,
  input  logic [2:0]                binPoint,
  input  logic                      dropValid,
  output logic [7:0]                runPrio,
  output logic                      runIsNmi,
  output logic [(1<<PRIO_BITS)-1:0] activeSet,
  output logic                      ackReject,
  output logic                      dropError
);

  rptStrobe_t        strobe;
  logic              setEmpty;
  logic [PRIO_W-1:0] curRun;

  assign runPrio = curRun;

  rpt_ctrl #(.PRIO_BITS(PRIO_BITS)) u_ctrl (
    .ackValid  (ackValid),
    .ackPrio   (ackPrio),
    .ackNmi    (ackNmi),
    .binPoint  (binPoint),
    .dropValid (dropValid),
    .curRunPrio(curRun),
    .setEmpty  (setEmpty),
    .strobe    (strobe)
  );

  rpt_datapath #(.PRIO_BITS(PRIO_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .runPrio  (curRun),
    .runIsNmi (runIsNmi),
    .setEmpty (setEmpty),
    .activeSet(activeSet),
    .ackReject(ackReject),
    .dropError(dropError)
  );

endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
  parameter int PRIO_BITS = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      ackValid,
  input logic [7:0]                ackPrio,
  input logic [2:0]                binPoint,
  input logic                      dropValid,
  input logic [7:0]                runPrio,
  input logic                      runIsNmi,
  input logic [(1<<PRIO_BITS)-1:0] activeSet,
  input logic                      ackReject,
  input logic                      dropError
);

  localparam int SHIFT = 8 - PRIO_BITS;

  logic [7:0] gp;
  always_comb begin
    gp = ackPrio;
    for (int b = 0; b < 8; b++) begin
      if (b <= int'(binPoint) || b < SHIFT) gp[b] = 1'b0;
    end
  end

  p_idle_value_r1: assert property (@(posedge clk) disable iff (!rstN)
    (activeSet == '0) |-> (runPrio == 8'hFF && !runIsNmi));

  p_active_not_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (activeSet != '0) |-> (runPrio != 8'hFF));

  p_accept_sets_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !dropValid && gp < runPrio) |=> (runPrio == $past(gp) && !ackReject));

  p_reject_keeps_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !dropValid && gp >= runPrio) |=> (ackReject && $stable(activeSet)));

  p_drop_pops_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dropValid && !ackValid && activeSet != '0) |=>
      ($countones(activeSet) == $countones($past(activeSet)) - 1 && !dropError));

  p_drop_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dropValid && !ackValid && activeSet == '0) |=> (dropError && activeSet == '0));

  p_both_same_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && dropValid && activeSet != '0 && gp < runPrio) |=>
      ($countones(activeSet) == $countones($past(activeSet)) && runPrio <= $past(gp)));

endmodule

bind rpt_running_prio rpt_checker #(.PRIO_BITS(PRIO_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ackValid (ackValid),
  .ackPrio  (ackPrio),
  .binPoint (binPoint),
  .dropValid(dropValid),
  .runPrio  (runPrio),
  .runIsNmi (runIsNmi),
  .activeSet(activeSet),
  .ackReject(ackReject),
  .dropError(dropError)
);

// File: tb/tb_rpt_running_prio.sv
module tb_rpt_running_prio;

  localparam int CLK_PERIOD = 10;
  localparam int PB = 5;
  localparam int LV = 1 << PB;

  typedef struct packed {
    logic        ack;
    logic [7:0]  prio;
    logic        nmi;
    logic [2:0]  bp;
    logic        drop;
    logic [7:0]  expRun;
    logic        expNmi;
    logic        expRej;
    logic        expDerr;
    logic [31:0] expSet;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'hA5, 1'b0, 3'd2, 1'b0, 8'hA0, 1'b0, 1'b0, 1'b0, 32'h0010_0000}, // R2
    '{1'b1, 8'h47, 1'b0, 3'd2, 1'b0, 8'h40, 1'b0, 1'b0, 1'b0, 32'h0010_0100}, // R3
    '{1'b1, 8'h40, 1'b0, 3'd2, 1'b0, 8'h40, 1'b0, 1'b1, 1'b0, 32'h0010_0100}, // R5 equal
    '{1'b1, 8'h90, 1'b0, 3'd2, 1'b0, 8'h40, 1'b0, 1'b1, 1'b0, 32'h0010_0100}, // R5 lower
    '{1'b1, 8'h1F, 1'b1, 3'd3, 1'b0, 8'h10, 1'b1, 1'b0, 1'b0, 32'h0010_0104}, // R7 nmi
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 32'h0010_0100}, // R4
    '{1'b1, 8'h2C, 1'b0, 3'd2, 1'b1, 8'h28, 1'b0, 1'b0, 1'b0, 32'h0010_0020}, // R8
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 8'hA0, 1'b0, 1'b0, 1'b0, 32'h0010_0000}, // R4
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R4
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 32'h0000_0000}, // R6
    '{1'b1, 8'h08, 1'b0, 3'd4, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 32'h0000_0001}, // R2
    '{1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0000_0001}, // R5
    '{1'b1, 8'h30, 1'b0, 3'd2, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 32'h0000_0000}, // R8
    '{1'b1, 8'hFF, 1'b1, 3'd0, 1'b0, 8'hF8, 1'b1, 1'b0, 1'b0, 32'h8000_0000}, // R2 R7
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000}  // R4
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ackValid = 1'b0;
  logic [7:0]    ackPrio = '0;
  logic          ackNmi = 1'b0;
  logic [2:0]    binPoint = '0;
  logic          dropValid = 1'b0;
  logic [7:0]    runPrio;
  logic          runIsNmi;
  logic [LV-1:0] activeSet;
  logic          ackReject;
  logic          dropError;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpt_running_prio #(.PRIO_BITS(PB)) dut (
    .clk(clk), .rstN(rstN), .ackValid(ackValid), .ackPrio(ackPrio),
    .ackNmi(ackNmi), .binPoint(binPoint), .dropValid(dropValid),
    .runPrio(runPrio), .runIsNmi(runIsNmi), .activeSet(activeSet),
    .ackReject(ackReject), .dropError(dropError)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // Drive one cycle of stimulus, then sample just after the edge.
  task automatic step(logic a, logic [7:0] p, logic n, logic [2:0] b, logic d);
    @(negedge clk);
    ackValid = a; ackPrio = p; ackNmi = n; binPoint = b; dropValid = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    ackValid = 1'b0; dropValid = 1'b0; ackNmi = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R1 run", 32'(runPrio), 32'hFF);
    check("R1 set", 32'(activeSet), 32'h0);
    check("R1 nmi", 32'(runIsNmi), 32'h0);
    check("R1 err", 32'({ackReject, dropError}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ackValid = VECS[i].ack; ackPrio = VECS[i].prio; ackNmi = VECS[i].nmi;
      binPoint = VECS[i].bp; dropValid = VECS[i].drop;
      @(posedge clk);
      #1;
      check($sformatf("vec%0d run R2/R4", i), 32'(runPrio), 32'(VECS[i].expRun));
      check($sformatf("vec%0d nmi R7", i), 32'(runIsNmi), 32'(VECS[i].expNmi));
      check($sformatf("vec%0d reject R5", i), 32'(ackReject), 32'(VECS[i].expRej));
      check($sformatf("vec%0d dropErr R6", i), 32'(dropError), 32'(VECS[i].expDerr));
      check($sformatf("vec%0d set R3 R8", i), 32'(activeSet), VECS[i].expSet);
    end
    @(negedge clk);
    ackValid = 1'b0; dropValid = 1'b0; ackNmi = 1'b0;
    #1;
    check("R5 pulse one cycle", 32'({ackReject, dropError}), 32'h0);

    // R3: deepest nesting, every level from least to most urgent.
    for (int k = LV - 1; k >= 0; k--) begin
      step(1'b1, 8'(k * 8), 1'b0, 3'd2, 1'b0);
      check("R3 nest run", 32'(runPrio), 32'(k * 8));
    end
    check("R3 full set", 32'(activeSet), 32'hFFFF_FFFF);

    // R4: unwind one level per drop.
    for (int k = 0; k < LV; k++) begin
      step(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
      check("R4 unwind run", 32'(runPrio), (k == LV - 1) ? 32'hFF : 32'((k + 1) * 8));
    end

    // R1: reset in the middle of a nest.
    step(1'b1, 8'h60, 1'b1, 3'd2, 1'b0);
    step(1'b1, 8'h20, 1'b1, 3'd2, 1'b0);
    check("R7 nested nmi", 32'(runIsNmi), 32'h1);
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    #1;
    check("R1 reset run", 32'(runPrio), 32'hFF);
    check("R1 reset set", 32'(activeSet), 32'h0);
    check("R1 reset nmi", 32'(runIsNmi), 32'h0);
    @(negedge clk) rstN = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule